// File: doc/BRIEF.md
# Short Position Command Frame Decoder

This block sits behind a byte-level LIN receiver in a stepper-motor node. The receiver hands it one byte at a time: first the protected identifier, which is flagged as the start of a frame, then the data bytes, then the checksum. The decoder recognises the short absolute-position command. It reads the form of the command from two identifier bits: a two-data-byte form that names one motor, and a four-data-byte form that carries one address and position slot for each of two motors. It accumulates the classic LIN checksum over the data bytes and compares the inverted sum with the received checksum byte.

When the checksum is good and the node is in half-step mode, the decoder looks for a target. A short frame is taken if its broadcast flag is clear or if its address field equals the node's 4-bit address. A long frame is taken from the first slot whose address matches. The chosen 11-bit two's-complement set point is then presented with a one-cycle load strobe. A checksum mismatch discards the frame and pulses an error flag. A frame that the receiver ends before the checksum byte is dropped without any output.

Top module: `spos_frame_decoder`

## Requirements
- R1: While `rst_n` is low, `pos_load`, `frame_error` and `pos_value` are all 0.
- R2: Short form (identifier bit 5 = 0): two data bytes D1 and D2 follow the identifier. The set point is {D1[7:5], D2[7:0]}, the broadcast flag is D1[4] and the address is D1[3:0]. When the flag is 1 and the address equals `node_addr`, `pos_load` is high for exactly one cycle, in the cycle after the checksum byte is presented. In that same cycle `pos_value` shows the set point.
- R3: In the short form, a broadcast flag of 0 loads the set point whatever `node_addr` is.
- R4: In the short form, a broadcast flag of 1 together with an address different from `node_addr` produces no load.
- R5: Long form (identifier bits 5:4 = 2'b10): four data bytes follow, forming slot 1 (bytes 1 and 2) and slot 2 (bytes 3 and 4). Each slot has the same layout as the short form. The set point loaded is taken from the slot whose address equals `node_addr`. When both slots match, slot 1 wins. When neither slot matches, nothing is loaded.
- R6: A start byte with identifier bits 5:4 = 2'b11 is not this command. The bytes that follow it produce no load and no error.
- R7: A frame with a good checksum produces no load when `step_mode` is not 2'b00 in the checksum-byte cycle.
- R8: When the checksum byte differs from the inverted carry-wrapped sum of the data bytes, no load occurs and `frame_error` is high for one cycle after the checksum byte. This holds for any step mode and any address.
- R9: When `rx_end` is asserted while a frame still lacks its checksum byte, the frame is dropped. Bytes that arrive after that, up to the next start byte, produce neither a load nor an error.
- R10: `pos_value` changes only in a cycle in which `pos_load` is high, and it otherwise keeps the last value loaded.
- R11: In the checksum, each carry out of bit 7 is added back into bit 0. For data 0xFF, 0xFF the checksum byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_start | input | 1 | With rx_valid: this byte is the protected identifier |
| rx_end | input | 1 | Receiver reports frame end or bus idle |
| node_addr | input | 4 | Physical address of this node |
| step_mode | input | 2 | Configured step mode; 2'b00 is half stepping |
| pos_load | output | 1 | One-cycle strobe: new set point on pos_value |
| pos_value | output | 11 | Signed set point, held between loads |
| frame_error | output | 1 | One-cycle pulse on a checksum mismatch |

## Verification
The bench covers the following corner cases and what a faulty design would do in each:
- Two-slot frames where only slot 2 matches, where both slots match, and where neither matches. A wrong priority or a wrong slot index would load the other slot's position or load nothing.
- A short frame with the broadcast flag cleared, sent to a node whose address differs. An inverted flag sense would either skip this frame or let addressed frames reach every node.
- An all-ones frame whose checksum is 0x00 only if the carry is wrapped back, and whose position is -1. Without the wrap the frame would be rejected as a checksum error; a sign or bit-slice fault would show up in the loaded value.
- Step-mode gating, the ignored identifier form, and a frame cut off by `rx_end` and then followed by its own remaining bytes. A decoder that misses the abort would load those stray bytes; one that does not gate on step mode would load in the wrong mode.

// File: rtl/spos_pkg.sv
package spos_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_SHORT = 2'd1,
    FK_LONG  = 2'd2
  } frame_kind_e;

  // One step of the carry-wrapped 8-bit sum
  function automatic logic [BYTE_W-1:0] csum_add(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] s;
    s = {1'b0, acc} + {1'b0, b};
    return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
  endfunction
endpackage

// File: rtl/spos_byte_tracker.sv
module spos_byte_tracker
  import spos_pkg::*;
#(
  parameter int SHORT_BYTES = 2,
  parameter int LONG_BYTES  = 4,
  localparam int IDX_W = $clog2(LONG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_start,
  input  logic              rx_end,
  output logic              frame_start,
  output frame_kind_e       kind,
  output logic              data_we,
  output logic [IDX_W-1:0]  data_idx,
  output logic              csum_we
);
  logic             active_q, active_d;
  frame_kind_e      kind_q, kind_d, id_kind;
  logic [IDX_W-1:0] need_q, need_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             byte_in;

  always_comb begin
    frame_start = rx_valid && rx_start;
    if (!rx_byte[5])      id_kind = FK_SHORT;
    else if (!rx_byte[4]) id_kind = FK_LONG;
    else                  id_kind = FK_NONE;
    byte_in  = active_q && rx_valid && !rx_start;
    data_we  = byte_in && (idx_q < need_q);
    csum_we  = byte_in && (idx_q == need_q);
    data_idx = idx_q;
    kind     = kind_q;
  end

  always_comb begin
    active_d = active_q;
    kind_d   = kind_q;
    need_d   = need_q;
    idx_d    = idx_q;
    if (frame_start) begin
      active_d = (id_kind != FK_NONE);
      kind_d   = id_kind;
      need_d   = (id_kind == FK_LONG) ? IDX_W'(LONG_BYTES) : IDX_W'(SHORT_BYTES);
      idx_d    = '0;
    end else if (csum_we) begin
      active_d = 1'b0;
    end else begin
      if (data_we) idx_d = idx_q + 1'b1;
      if (rx_end)  active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= FK_NONE;
      need_q   <= '0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      kind_q   <= kind_d;
      need_q   <= need_d;
      idx_q    <= idx_d;
    end
  end
endmodule

// File: rtl/spos_csum_acc.sv
module spos_csum_acc
  import spos_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] expected
);
  logic [BYTE_W-1:0] acc_q, acc_d;
  logic              acc_en;

  always_comb begin
    acc_en = clr || add;
    acc_d  = clr ? '0 : csum_add(acc_q, din);
    expected = ~acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/spos_slot_store.sv
module spos_slot_store
  import spos_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int POS_W  = 11,
  parameter int ADDR_W = 4,
  localparam int NBYTES = 2 * SLOTS,
  localparam int HI_W   = POS_W - BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             idx,
  input  logic [BYTE_W-1:0]            din,
  output logic [SLOTS-1:0][POS_W-1:0]  slot_pos,
  output logic [SLOTS-1:0][ADDR_W-1:0] slot_addr,
  output logic [SLOTS-1:0]             slot_flag
);
  logic [NBYTES-1:0][BYTE_W-1:0] byte_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic en;
    assign en = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q[g] <= '0;
      else if (en) byte_q[g] <= din;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_pos[s]  = {byte_q[2*s][BYTE_W-1 -: HI_W], byte_q[2*s+1]};
    assign slot_addr[s] = byte_q[2*s][ADDR_W-1:0];
    assign slot_flag[s] = byte_q[2*s][ADDR_W];
  end
endmodule

// File: rtl/spos_frame_decoder.sv
module spos_frame_decoder
  import spos_pkg::*;
#(
  parameter int POS_W  = 11,
  parameter int ADDR_W = 4,
  parameter int SLOTS  = 2,
  localparam int NBYTES = 2 * SLOTS,
  localparam int IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_start,
  input  logic              rx_end,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic [1:0]        step_mode,
  output logic              pos_load,
  output logic [POS_W-1:0]  pos_value,
  output logic              frame_error
);
  logic                         frame_start, data_we, csum_we;
  frame_kind_e                  kind;
  logic [IDX_W-1:0]             data_idx;
  logic [BYTE_W-1:0]            csum_exp;
  logic [SLOTS-1:0][POS_W-1:0]  slot_pos;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [SLOTS-1:0]             slot_flag;

  spos_byte_tracker #(.SHORT_BYTES(2), .LONG_BYTES(NBYTES)) u_track (
    .clk, .rst_n, .rx_valid, .rx_byte, .rx_start, .rx_end,
    .frame_start, .kind, .data_we, .data_idx, .csum_we
  );

  spos_csum_acc u_csum (
    .clk, .rst_n, .clr(frame_start), .add(data_we), .din(rx_byte),
    .expected(csum_exp)
  );

  spos_slot_store #(.SLOTS(SLOTS), .POS_W(POS_W), .ADDR_W(ADDR_W)) u_store (
    .clk, .rst_n, .we(data_we), .idx(data_idx), .din(rx_byte),
    .slot_pos, .slot_addr, .slot_flag
  );

  logic             hit, csum_ok, mode_ok;
  logic [POS_W-1:0] pick_pos;
  logic             load_d, err_d;

  always_comb begin
    hit      = 1'b0;
    pick_pos = slot_pos[0];
    if (kind == FK_SHORT) begin
      hit = !slot_flag[0] || (slot_addr[0] == node_addr);
    end else if (kind == FK_LONG) begin
      // Walk from the last slot down so the lowest matching slot wins
      for (int i = SLOTS - 1; i >= 0; i--) begin
        if (slot_addr[i] == node_addr) begin
          hit      = 1'b1;
          pick_pos = slot_pos[i];
        end
      end
    end
    csum_ok = (rx_byte == csum_exp);
    mode_ok = (step_mode == 2'b00);
    load_d  = csum_we && csum_ok && mode_ok && hit;
    err_d   = csum_we && !csum_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_load    <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      pos_load    <= load_d;
      frame_error <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_value <= '0;
    else if (load_d) pos_value <= pick_pos;
  end
endmodule

// File: rtl/spos_frame_decoder_chk.sv
module spos_frame_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_start,
  input logic [1:0]  step_mode,
  input logic        pos_load,
  input logic [10:0] pos_value,
  input logic        frame_error
);
  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_load |=> !pos_load);

  assert_mode_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_load |-> ($past(step_mode) == 2'b00));

  assert_no_load_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_load && frame_error));

  assert_err_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |-> $past(rx_valid && !rx_start));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_value) |-> pos_load);
endmodule

bind spos_frame_decoder spos_frame_decoder_chk u_chk (.*);

// File: tb/spos_frame_decoder_bench.sv
module spos_frame_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_start, rx_end;
  logic [7:0]  rx_byte;
  logic [3:0]  node_addr;
  logic [1:0]  step_mode;
  logic        pos_load, frame_error;
  logic [10:0] pos_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [10:0] last_pos;

  always #10 clk = ~clk;

  spos_frame_decoder u_spos_frame_decoder (
    .clk, .rst_n, .rx_valid, .rx_byte, .rx_start, .rx_end,
    .node_addr, .step_mode, .pos_load, .pos_value, .frame_error
  );

  // [63:56] id, [55:24] data bytes 1..4, [23] corrupt checksum, [22:19] node,
  // [18:17] mode, [16] expect load, [15:5] expect pos, [4] expect error
  localparam int NV = 12;
  localparam logic [63:0] VEC [NV] = '{
    {8'h05, 32'hB35A0000, 1'b0, 4'h3, 2'b00, 1'b1, 11'h55A, 1'b0, 4'h0}, // R2
    {8'h05, 32'h69120000, 1'b0, 4'h3, 2'b00, 1'b1, 11'h312, 1'b0, 4'h0}, // R3
    {8'h05, 32'h79120000, 1'b0, 4'h3, 2'b00, 1'b0, 11'h000, 1'b0, 4'h0}, // R4
    {8'h23, 32'h5344D788, 1'b0, 4'h7, 2'b00, 1'b1, 11'h688, 1'b0, 4'h0}, // R5 slot 2
    {8'h23, 32'h5344D788, 1'b0, 4'h3, 2'b00, 1'b1, 11'h244, 1'b0, 4'h0}, // R5 slot 1
    {8'h23, 32'h5345D388, 1'b0, 4'h3, 2'b00, 1'b1, 11'h245, 1'b0, 4'h0}, // R5 both
    {8'h23, 32'h5344D788, 1'b0, 4'h5, 2'b00, 1'b0, 11'h000, 1'b0, 4'h0}, // R5 none
    {8'h05, 32'hB35A0000, 1'b0, 4'h3, 2'b01, 1'b0, 11'h000, 1'b0, 4'h0}, // R7
    {8'h05, 32'hB35A0000, 1'b0, 4'h3, 2'b10, 1'b0, 11'h000, 1'b0, 4'h0}, // R7
    {8'h05, 32'hB35A0000, 1'b1, 4'h3, 2'b00, 1'b0, 11'h000, 1'b1, 4'h0}, // R8
    {8'h35, 32'hB35A1234, 1'b0, 4'h3, 2'b00, 1'b0, 11'h000, 1'b0, 4'h0}, // R6
    {8'hC5, 32'hFFFF0000, 1'b0, 4'hF, 2'b00, 1'b1, 11'h7FF, 1'b0, 4'h0}  // R11
  };

  function automatic logic [7:0] lin_sum(input logic [31:0] d, input int n);
    logic [8:0] s;
    logic [7:0] a = 8'h00;
    for (int i = 0; i < n; i++) begin
      s = {1'b0, a} + {1'b0, d[31-8*i -: 8]};
      a = s[7:0] + {7'd0, s[8]};
    end
    return ~a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic st);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    rx_start = st;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    rx_valid = 1'b0;
    rx_start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_start = 1'b0; rx_end = 1'b0;
    rx_byte = 8'h00; node_addr = 4'h0; step_mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 load", {31'd0, pos_load}, 32'd0);
    check("R1 err",  {31'd0, frame_error}, 32'd0);
    check("R1 pos",  {21'd0, pos_value}, 32'd0);
    rst_n = 1'b1;
    last_pos = 11'h000;

    for (int v = 0; v < NV; v++) begin
      logic [63:0] e;
      int n;
      logic [7:0] cs;
      e = VEC[v];
      n = e[61] ? 4 : 2;
      node_addr = e[22:19];
      step_mode = e[18:17];
      cs = lin_sum(e[55:24], n) ^ {7'd0, e[23]};
      put(e[63:56], 1'b1);
      for (int i = 0; i < n; i++) put(e[55-8*i -: 8], 1'b0);
      put(cs, 1'b0);
      idle_cycle();
      if (e[16]) last_pos = e[15:5];
      check($sformatf("R%0s vec%0d load", e[16] ? "2/R3/R5" : "4/R6/R7/R8", v),
            {31'd0, pos_load}, {31'd0, e[16]});
      check($sformatf("R8 vec%0d err", v), {31'd0, frame_error}, {31'd0, e[4]});
      check($sformatf("R10 vec%0d pos", v), {21'd0, pos_value}, {21'd0, last_pos});
      idle_cycle();
      check($sformatf("R2 vec%0d strobe width", v), {31'd0, pos_load}, 32'd0);
    end

    // R11: the all-ones frame checksum is 0x00 once the carry wraps
    check("R11 checksum", {24'd0, lin_sum(32'hFFFF0000, 2)}, 32'h00);

    // R9: early end, then the rest of the frame arrives as stray bytes
    node_addr = 4'h3; step_mode = 2'b00;
    put(8'h05, 1'b1);
    put(8'hB3, 1'b0);
    @(negedge clk); rx_valid = 1'b0; rx_end = 1'b1;
    @(negedge clk); rx_end = 1'b0;
    put(8'h5A, 1'b0);
    put(lin_sum(32'hB35A0000, 2), 1'b0);
    idle_cycle();
    check("R9 load", {31'd0, pos_load}, 32'd0);
    check("R9 err",  {31'd0, frame_error}, 32'd0);
    check("R9 pos",  {21'd0, pos_value}, {21'd0, last_pos});

    // R9: a full frame after the abort still decodes
    put(8'h05, 1'b1);
    put(8'hB3, 1'b0);
    put(8'h5A, 1'b0);
    put(lin_sum(32'hB35A0000, 2), 1'b0);
    idle_cycle();
    check("R9 recover load", {31'd0, pos_load}, 32'd1);
    check("R9 recover pos",  {21'd0, pos_value}, 32'h55A);

    // R1: reset in operation clears the held set point
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset pos", {21'd0, pos_value}, 32'd0);
    check("R1 mid reset load", {31'd0, pos_load}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule